// File: doc/BRIEF.md
# Per-Port Link Hold-Off Control

This block decides, for each of a set of PHY ports, whether that port's transmitter and receiver may run or must stay powered down. It lets a board keep every link down from power-up until configuration firmware has finished. A single board-level hold-off pin is sampled while hardware reset is asserted. Its captured level becomes the hold-off default for all ports. Software then brings ports up one at a time by clearing a bit in that port's control register.

A per-port software reset puts that port's register back to its defaults. This includes the hold-off bit, which is reloaded from the captured pin level, so a single port can be held off again without touching its neighbours. While a port is held off, register reads and writes keep working. The block only drives the power-down request; the analog front end, autonegotiation and LEDs lie outside it.

Each port has a small state machine with three states:

- `P_ACTIVE`: the port is released.
- `P_HELD`: the port is held off.
- `P_RESET`: a reset is pending for one cycle.

Its transitions are:

- `P_ACTIVE`/`P_HELD` to `P_HELD` on a write with bit 11 set.
- `P_ACTIVE`/`P_HELD` to `P_ACTIVE` on a write with bit 11 clear.
- `P_ACTIVE`/`P_HELD` to `P_RESET` on a write with bit 15 set.
- `P_RESET` to `P_HELD` or `P_ACTIVE` after one cycle, chosen by the captured pin level.

Hardware reset forces every port into `P_RESET`.

Top module: `linkhold_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, the block captures `hold_pin` through a synchronizer. One cycle after reset is released, every port's control register 0 reads bit 11 (hold-off) equal to the captured level, and every `pwr_dn` bit equals it.
- R2: After hardware reset, changes on `hold_pin` have no effect on any port's hold-off bit or on `pwr_dn`.
- R3: A write to register 0 of port p with bit 15 = 0 and bit 11 = 0 clears the hold-off of port p only. Every other port keeps its hold-off bit.
- R4: A write to register 0 of port p with bit 15 = 0 and bit 11 = 1 places port p in hold-off, and `pwr_dn[p]` becomes 1 in the cycle after the write edge.
- R5: `pwr_dn[p]` is 1 exactly when port p's hold-off bit (bit 11) or its normal power-down bit (bit 10 of register 0) is 1. The two bits are separate fields.
- R6: A write to register 0 of port p with bit 15 = 1 starts a software reset of port p. In the following cycle, register 0 reads bit 15 = 1, bit 11 = the captured pin level, and all other bits 0. One cycle later bit 15 reads 0 and bit 11 keeps the captured level. Other ports are unaffected.
- R7: A write to a port whose software reset is pending (bit 15 reading 1) is ignored.
- R8: The storage bits 14:12 and 9:0 of register 0 read back what was last written, whether or not the port is held off.
- R9: Writes to a register address other than 0, or to a port address at or above `NUM_PORTS`, change nothing. Reads of those locations return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, synchronous; the pin is captured while it is low |
| hold_pin | input | 1 | Board-level hold-off strap, active high |
| wr_en | input | 1 | Register write strobe for one cycle |
| port_addr | input | ADDR_W | Port selected for read and write |
| reg_addr | input | 5 | Register selected within the port; only 0 is populated |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for the addressed port and register |
| pwr_dn | output | NUM_PORTS | Per-port transmitter and receiver power-down request |

## Verification
The bench builds the block with `NUM_PORTS` = 6 and `ADDR_W` = 3. Port addresses 6 and 7 therefore exist on the bus but have no port behind them, which lets the out-of-range write and read cases of R9 be observed. `SYNC_STAGES` stays at 2, and each hardware reset is held long enough for the pin to cross the synchronizer. Both captured levels are exercised: level 0 for the vector table, and level 1 for per-port release and for a software reset that re-holds a single port.

// File: rtl/linkhold_pkg.sv
package linkhold_pkg;

    localparam int DATA_W   = 16;
    localparam int REG_AW   = 5;
    localparam int CTRL_REG = 0;

    localparam int BIT_SWRST = 15;
    localparam int BIT_HOLD  = 11;
    localparam int BIT_PDN   = 10;

    localparam logic [DATA_W-1:0] STORE_MASK = 16'h73FF;

    typedef enum logic [1:0] {
        P_ACTIVE = 2'd0,
        P_HELD   = 2'd1,
        P_RESET  = 2'd2
    } port_st_e;

endpackage

// File: rtl/linkhold_capture.sv
module linkhold_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic hold_pin,
    output logic cap_q
);

    logic pin_sync;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                s_q <= hold_pin;
            end
            assign pin_sync = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                s_q <= {s_q[SYNC_STAGES-2:0], hold_pin};
            end
            assign pin_sync = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // Loaded only while hardware reset is asserted; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            cap_q <= pin_sync;
        end
    end

endmodule

// File: rtl/linkhold_port.sv
module linkhold_port
    import linkhold_pkg::*;
(
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              cap_hold,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              hold_o,
    output logic              pdn_o,
    output logic              pend_o,
    output logic              pwr_dn_o
);

    port_st_e          state_q;
    port_st_e          state_d;
    logic [DATA_W-1:0] store_q;
    logic              pdn_q;
    logic              accept;

    assign accept = wr_stb && (state_q != P_RESET);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_ACTIVE, P_HELD: begin
                if (wr_stb) begin
                    if (wdata[BIT_SWRST]) begin
                        state_d = P_RESET;
                    end else if (wdata[BIT_HOLD]) begin
                        state_d = P_HELD;
                    end else begin
                        state_d = P_ACTIVE;
                    end
                end
            end
            P_RESET: begin
                state_d = cap_hold ? P_HELD : P_ACTIVE;
            end
            default: begin
                state_d = P_RESET;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            state_q <= P_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Plain register fields
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            store_q <= '0;
            pdn_q   <= 1'b0;
        end else if (accept) begin
            if (wdata[BIT_SWRST]) begin
                store_q <= '0;
                pdn_q   <= 1'b0;
            end else begin
                store_q <= wdata & STORE_MASK;
                pdn_q   <= wdata[BIT_PDN];
            end
        end
    end

    // Outputs
    always_comb begin
        hold_o = 1'b0;
        pend_o = 1'b0;
        unique case (state_q)
            P_ACTIVE: hold_o = 1'b0;
            P_HELD:   hold_o = 1'b1;
            P_RESET: begin
                hold_o = cap_hold;
                pend_o = 1'b1;
            end
            default: begin
                hold_o = 1'b1;
                pend_o = 1'b1;
            end
        endcase
        pdn_o              = pdn_q;
        pwr_dn_o           = hold_o | pdn_q;
        ctrl_word          = store_q;
        ctrl_word[BIT_HOLD]  = hold_o;
        ctrl_word[BIT_PDN]   = pdn_q;
        ctrl_word[BIT_SWRST] = pend_o;
    end

endmodule

// File: rtl/linkhold_ctrl.sv
module linkhold_ctrl
    import linkhold_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 hw_rst_n,
    input  logic                 hold_pin,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    port_addr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_PORTS-1:0] pwr_dn
);

    logic                 cap_q;
    logic                 reg_hit;
    logic [NUM_PORTS-1:0] wr_stb;
    logic [NUM_PORTS-1:0] hold_vec;
    logic [NUM_PORTS-1:0] pdn_vec;
    logic [NUM_PORTS-1:0] pend_vec;
    logic [DATA_W-1:0]    ctrl_words [NUM_PORTS];

    assign reg_hit = (reg_addr == REG_AW'(CTRL_REG));

    linkhold_capture #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .hold_pin (hold_pin),
        .cap_q    (cap_q)
    );

    generate
        for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
            assign wr_stb[gi] = wr_en && reg_hit && (port_addr == ADDR_W'(gi));

            linkhold_port u_port (
                .clk       (clk),
                .hw_rst_n  (hw_rst_n),
                .cap_hold  (cap_q),
                .wr_stb    (wr_stb[gi]),
                .wdata     (wdata),
                .ctrl_word (ctrl_words[gi]),
                .hold_o    (hold_vec[gi]),
                .pdn_o     (pdn_vec[gi]),
                .pend_o    (pend_vec[gi]),
                .pwr_dn_o  (pwr_dn[gi])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (reg_hit && (port_addr == ADDR_W'(i))) begin
                rdata = ctrl_words[i];
            end
        end
    end

endmodule

// File: rtl/linkhold_chk.sv
module linkhold_chk #(
    parameter int NUM_PORTS = 8,
    parameter int ADDR_W    = 3
) (
    input logic                 clk,
    input logic                 hw_rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    port_addr,
    input logic [4:0]           reg_addr,
    input logic [15:0]          wdata,
    input logic                 cap_q,
    input logic [NUM_PORTS-1:0] hold_vec,
    input logic [NUM_PORTS-1:0] pdn_vec,
    input logic [NUM_PORTS-1:0] pend_vec,
    input logic [NUM_PORTS-1:0] pwr_dn
);

    localparam logic [ADDR_W:0] PORT_LIMIT = (ADDR_W+1)'(NUM_PORTS);

    logic out_of_range;
    assign out_of_range = ({1'b0, port_addr} >= PORT_LIMIT);

    AST_RELEASE_CAPTURE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(hw_rst_n) |=> (hold_vec == {NUM_PORTS{cap_q}})); // R1

    AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!hw_rst_n)
        hw_rst_n |=> $stable(cap_q)); // R2

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!wr_en && (pend_vec == '0)) |=> $stable(hold_vec)); // R2

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (wr_en && out_of_range && (pend_vec == '0)) |=> ($stable(hold_vec) && $stable(pdn_vec))); // R9

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            AST_SW_HOLD_WRITE: assert property (@(posedge clk) disable iff (!hw_rst_n)
                (wr_en && (port_addr == ADDR_W'(p)) && (reg_addr == 5'd0) && !pend_vec[p] && !wdata[15])
                |=> (hold_vec[p] == $past(wdata[11]))); // R3

            AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
                pend_vec[p] |=> !pend_vec[p]); // R6

            AST_SWRST_RELOAD: assert property (@(posedge clk) disable iff (!hw_rst_n)
                pend_vec[p] |=> (hold_vec[p] == $past(cap_q))); // R6

            AST_PEND_IGNORES: assert property (@(posedge clk) disable iff (!hw_rst_n)
                pend_vec[p] |=> !pdn_vec[p]); // R7

            AST_PWRDN_HOLD: assert property (@(posedge clk) disable iff (!hw_rst_n)
                hold_vec[p] |-> pwr_dn[p]); // R5

            AST_PWRDN_IDLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
                (!hold_vec[p] && !pdn_vec[p]) |-> !pwr_dn[p]); // R5
        end
    endgenerate

endmodule

bind linkhold_ctrl linkhold_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .hw_rst_n  (hw_rst_n),
    .wr_en     (wr_en),
    .port_addr (port_addr),
    .reg_addr  (reg_addr),
    .wdata     (wdata),
    .cap_q     (cap_q),
    .hold_vec  (hold_vec),
    .pdn_vec   (pdn_vec),
    .pend_vec  (pend_vec),
    .pwr_dn    (pwr_dn)
);

// File: tb/sim_linkhold_ctrl.sv
`timescale 1ns/1ps
module sim_linkhold_ctrl;

    localparam int NP = 6;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic          hold_pin = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] port_addr = '0;
    logic [4:0]    reg_addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [NP-1:0] pwr_dn;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    linkhold_ctrl #(
        .NUM_PORTS   (NP),
        .ADDR_W      (AW),
        .SYNC_STAGES (2)
    ) u0 (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .hold_pin  (hold_pin),
        .wr_en     (wr_en),
        .port_addr (port_addr),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .pwr_dn    (pwr_dn)
    );

    typedef struct packed {
        logic [2:0]  port;
        logic [4:0]  radr;
        logic [15:0] data;
        logic [2:0]  rport;
        logic [15:0] exp;
        logic [5:0]  pwr;
        logic [3:0]  req;
    } vec_t;

    // Captured pin level is 0 for this table.
    localparam vec_t TBL [7] = '{
        '{3'd2, 5'd0, 16'h0800, 3'd2, 16'h0800, 6'b000100, 4'd4}, // R4 software hold
        '{3'd4, 5'd0, 16'h0400, 3'd4, 16'h0400, 6'b010100, 4'd5}, // R5 normal power-down
        '{3'd2, 5'd0, 16'h0C15, 3'd2, 16'h0C15, 6'b010100, 4'd8}, // R8 storage while held
        '{3'd2, 5'd0, 16'h0015, 3'd2, 16'h0015, 6'b010000, 4'd3}, // R3 release one port
        '{3'd6, 5'd0, 16'h0800, 3'd6, 16'h0000, 6'b010000, 4'd9}, // R9 missing port
        '{3'd1, 5'd3, 16'h0800, 3'd1, 16'h0000, 6'b010000, 4'd9}, // R9 other register
        '{3'd4, 5'd0, 16'h7000, 3'd4, 16'h7000, 6'b000000, 4'd8}  // R8 upper storage
    };

    task automatic check_rd(input logic [2:0] p, input logic [4:0] r,
                            input logic [15:0] exp, input logic [NP-1:0] pw,
                            input string tag);
        port_addr = p;
        reg_addr  = r;
        #1;
        total++;
        if (rdata !== exp || pwr_dn !== pw) begin
            bad++;
            $display("FAIL %s port%0d reg%0d: rdata=%h pwr_dn=%b expected rdata=%h pwr_dn=%b",
                     tag, p, r, rdata, pwr_dn, exp, pw);
        end
    endtask

    task automatic do_write(input logic [2:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        wr_en     = 1'b1;
        port_addr = p;
        reg_addr  = r;
        wdata     = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hw_reset(input logic lvl);
        @(negedge clk);
        hw_rst_n = 1'b0;
        hold_pin = lvl;
        repeat (4) @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset with pin low
        hw_reset(1'b0);
        for (int p = 0; p < NP; p++) check_rd(3'(p), 5'd0, 16'h0000, 6'b000000, "R1 pin-low reset");

        // R2 pin change after reset
        hold_pin = 1'b1;
        repeat (5) @(negedge clk);
        check_rd(3'd0, 5'd0, 16'h0000, 6'b000000, "R2 late pin high");

        foreach (TBL[i]) begin
            do_write(TBL[i].port, TBL[i].radr, TBL[i].data);
            check_rd(TBL[i].rport, 5'd0, TBL[i].exp, TBL[i].pwr, $sformatf("R%0d vector %0d", TBL[i].req, i));
        end

        // R6 software reset with captured level 0, R7 write during pending
        do_write(3'd4, 5'd0, 16'h8000);
        check_rd(3'd4, 5'd0, 16'h8000, 6'b000000, "R6 pending read");
        wr_en = 1'b1; port_addr = 3'd4; reg_addr = 5'd0; wdata = 16'h0C00;
        @(negedge clk);
        wr_en = 1'b0;
        check_rd(3'd4, 5'd0, 16'h0000, 6'b000000, "R7 write during pending ignored");

        // R1 reset with pin high
        hw_reset(1'b1);
        for (int p = 0; p < NP; p++) check_rd(3'(p), 5'd0, 16'h0800, 6'b111111, "R1 pin-high reset");
        hold_pin = 1'b0;
        repeat (5) @(negedge clk);
        check_rd(3'd2, 5'd0, 16'h0800, 6'b111111, "R2 late pin low");

        // R3 release ports one by one
        do_write(3'd0, 5'd0, 16'h0000);
        check_rd(3'd0, 5'd0, 16'h0000, 6'b111110, "R3 release port0");
        check_rd(3'd1, 5'd0, 16'h0800, 6'b111110, "R3 neighbour held");
        do_write(3'd3, 5'd0, 16'h0000);
        check_rd(3'd3, 5'd0, 16'h0000, 6'b110110, "R3 release port3");

        // R8 storage while held
        do_write(3'd1, 5'd0, 16'h0BFF);
        check_rd(3'd1, 5'd0, 16'h0BFF, 6'b110110, "R8 held port storage");

        // R6 software reset re-holds one port
        do_write(3'd0, 5'd0, 16'h8123);
        check_rd(3'd0, 5'd0, 16'h8800, 6'b110111, "R6 pending with level 1");
        @(negedge clk);
        check_rd(3'd0, 5'd0, 16'h0800, 6'b110111, "R6 self-clear");
        check_rd(3'd1, 5'd0, 16'h0BFF, 6'b110111, "R6 other port untouched");
        check_rd(3'd3, 5'd0, 16'h0000, 6'b110111, "R6 released port untouched");

        // R9 empty locations
        check_rd(3'd7, 5'd0, 16'h0000, 6'b110111, "R9 read missing port");
        check_rd(3'd1, 5'd2, 16'h0000, 6'b110111, "R9 read other register");
        do_write(3'd1, 5'd2, 16'h0000);
        check_rd(3'd1, 5'd0, 16'h0BFF, 6'b110111, "R9 write other register ignored");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule